// File: doc/BRIEF.md
# Processor Interrupt and Control Input Unit

This unit sits between the external control pins of a small 8-bit processor core and the core's instruction sequencer. It brings the asynchronous pins into the clock domain and detects their edges and levels. It keeps the pending requests and presents a 2-bit service code. The sequencer reads that code at each instruction boundary to decide which service routine to start. Fetching the vector for that service is not part of this unit.

Five pins are handled:
- A level-sensitive maskable interrupt, which the interrupt-disable flag can block.
- An edge-latched non-maskable interrupt that stays pending until it is serviced.
- A reset pin that holds the core stopped and then restarts it from the power-on state. The restart happens only after the pin has been released for a minimum number of cycles.
- An overflow-set pin whose falling edge, sampled in the late half of phase one, produces a one-cycle pulse that sets the overflow status flag.
- A ready pin that freezes the core at an opcode fetch, which allows stepping one instruction at a time.

Top module: `irqc_top`

## Requirements
- R1: Every pin passes through SYNC_STAGES flip-flops before it can act. With the default of two stages, a low level on the maskable interrupt pin changes svcCode after the second rising clock edge and not after the first.
- R2: The maskable interrupt is level sensitive and active low. While its synchronized level is low and intDisable is 0, svcCode reads 2'b01. While intDisable is 1, the maskable interrupt produces no request.
- R3: A falling edge on the non-maskable pin sets a pending request, so svcCode reads 2'b10 after the third rising edge. A pin held low after that request has been serviced raises no new request. A later high-then-low sequence raises a new one.
- R4: A pending non-maskable request stays pending however long it waits. It is cleared by the clock edge at which instrEnd is 1 while svcCode reads 2'b10.
- R5: Reset has priority over the non-maskable interrupt, which has priority over the maskable interrupt. The codes are 2'b11 for restart, 2'b10 for non-maskable, 2'b01 for maskable and 2'b00 for nothing pending. svcReq is 1 exactly when the code is not 2'b00.
- R6: While the reset pin is low, coreHold is 1 and svcCode reads 2'b11. This takes effect from the third edge after the pin falls. Once the synchronized reset level has been high for RELEASE_CYCLES consecutive edges, restartReq pulses for exactly one cycle and coreHold falls at that same edge. With defaults that is SYNC_STAGES+RELEASE_CYCLES edges after the pin rises.
- R7: A reset release shorter than RELEASE_CYCLES synchronized cycles produces no restart, and coreHold stays 1.
- R8: After sysRstN, the unit is in the held state: coreHold is 1, svcCode is 2'b11, and no other request is pending.
- R9: When ph1Late is 1 and the synchronized overflow-set pin is sampled falling, setOverflow is 1 for exactly one cycle. Holding the pin low produces no further pulse.
- R10: A fall on the overflow-set pin while ph1Late is 0 produces no pulse until ph1Late is next 1.
- R11: stall becomes 1 at an edge where ph2En and opFetch are 1 and the synchronized ready level is low. A low ready level without opFetch does not stall. stall clears at the first edge that samples a high synchronized ready level.
- R12: A non-maskable request, or a non-maskable edge, that arrives while reset is held is discarded. After the restart, svcCode reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| sysRstN | input | 1 | Power-on reset of the unit's flip-flops, active low |
| irqPinN | input | 1 | Maskable interrupt pin, active low, asynchronous |
| nmiPinN | input | 1 | Non-maskable interrupt pin, falling-edge active, asynchronous |
| resPinN | input | 1 | Processor reset pin, active low, asynchronous |
| soPinN | input | 1 | Overflow-set pin, falling-edge active, asynchronous |
| rdyPin | input | 1 | Ready pin, low requests a halt, asynchronous |
| intDisable | input | 1 | Interrupt-disable status flag of the core |
| instrEnd | input | 1 | Instruction-boundary strobe from the sequencer |
| opFetch | input | 1 | High while the current cycle fetches an opcode |
| ph1Late | input | 1 | Enable marking the late half of phase one |
| ph2En | input | 1 | Enable marking phase two |
| svcReq | output | 1 | A service is requested |
| svcCode | output | 2 | Selected service: 11 restart, 10 non-maskable, 01 maskable, 00 none |
| restartReq | output | 1 | One-cycle pulse that starts execution from the power-on state |
| coreHold | output | 1 | Holds the core stopped while reset is in effect |
| setOverflow | output | 1 | One-cycle pulse that sets the overflow status flag |
| stall | output | 1 | Freezes the core at an opcode fetch |

## Verification
The bench builds the unit with SYNC_STAGES=2 and RELEASE_CYCLES=3. With those values the restart latency is five edges, so an off-by-one error in either the synchronizer chain or the release counter shows up as a wrong edge count. A release of three cycles also makes it possible to apply a two-cycle reset glitch that passes the synchronizer but must still be rejected, which the default release length of two could not show apart from a one-cycle glitch. The two-stage chain keeps every latency check at the smallest depth that still separates the synchronized edge from the raw one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SVC_NONE  = 2'b00,
    SVC_IRQ   = 2'b01,
    SVC_NMI   = 2'b10,
    SVC_RESET = 2'b11
  } svcCode_t;

  localparam int PIN_COUNT = 5;
  localparam int PIN_IRQ = 0;
  localparam int PIN_NMI = 1;
  localparam int PIN_RES = 2;
  localparam int PIN_SO  = 3;
  localparam int PIN_RDY = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic takeNmi;
    logic fireRestart;
    logic setHalt;
  } ctlStrobes_t;

  // state from datapath to control
  typedef struct packed {
    logic irqLow;
    logic nmiPend;
    logic resPend;
    logic resHigh;
    logic relDone;
    logic rdyLow;
  } dpStatus_t;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= '1;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int RELEASE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        sysRstN,
  input  logic [PIN_COUNT-1:0] pinsRaw,
  input  logic        ph1Late,
  input  ctlStrobes_t stb,
  output dpStatus_t   stat,
  output logic        restartReq,
  output logic        coreHold,
  output logic        setOverflow,
  output logic        stall
);

  localparam int CNT_W = $clog2(RELEASE_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELEASE_CYCLES - 1);

  logic [PIN_COUNT-1:0] pinsSync;
  logic irqS, nmiS, resS, soS, rdyS;
  logic nmiPrev, nmiFall, nmiPend;
  logic resPend;
  logic [CNT_W-1:0] relCnt;
  logic soPrev, haltQ;

  irqc_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (sysRstN),
    .din  (pinsRaw),
    .dout (pinsSync)
  );

  assign irqS = pinsSync[PIN_IRQ];
  assign nmiS = pinsSync[PIN_NMI];
  assign resS = pinsSync[PIN_RES];
  assign soS  = pinsSync[PIN_SO];
  assign rdyS = pinsSync[PIN_RDY];

  assign nmiFall = nmiPrev & ~nmiS;

  // non-maskable edge latch, dropped while reset is in effect
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiS;
      if (resPend) nmiPend <= 1'b0;
      else         nmiPend <= nmiFall | (nmiPend & ~stb.takeNmi);
    end
  end

  // reset hold and release qualification
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      resPend    <= 1'b1;
      relCnt     <= '0;
      restartReq <= 1'b0;
    end else begin
      restartReq <= stb.fireRestart;
      if (!resS) begin
        resPend <= 1'b1;
        relCnt  <= '0;
      end else if (stb.fireRestart) begin
        resPend <= 1'b0;
        relCnt  <= '0;
      end else if (resPend) begin
        relCnt  <= relCnt + 1'b1;
      end else begin
        relCnt  <= '0;
      end
    end
  end

  // overflow-set edge, sampled only in late phase one
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      soPrev      <= 1'b1;
      setOverflow <= 1'b0;
    end else begin
      setOverflow <= ph1Late & soPrev & ~soS;
      if (ph1Late) soPrev <= soS;
    end
  end

  // ready halt
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)          haltQ <= 1'b0;
    else if (rdyS)         haltQ <= 1'b0;
    else if (stb.setHalt)  haltQ <= 1'b1;
  end

  assign coreHold = resPend;
  assign stall    = haltQ;

  assign stat.irqLow  = ~irqS;
  assign stat.nmiPend = nmiPend;
  assign stat.resPend = resPend;
  assign stat.resHigh = resS;
  assign stat.relDone = (relCnt == CNT_LAST);
  assign stat.rdyLow  = ~rdyS;

  AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (!sysRstN)
    (stb.takeNmi && !nmiFall) |=> !nmiPend); // R4
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!sysRstN)
    restartReq |=> !restartReq); // R6
  AST_HOLD_FALL: assert property (@(posedge clk) disable iff (!sysRstN)
    $fell(coreHold) |-> restartReq); // R6
  AST_OVF_ONE: assert property (@(posedge clk) disable iff (!sysRstN)
    setOverflow |=> !setOverflow); // R9
  AST_HALT_FETCH: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(stall) |-> $past(stb.setHalt)); // R11

endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        sysRstN,
  input  dpStatus_t   stat,
  input  logic        intDisable,
  input  logic        instrEnd,
  input  logic        opFetch,
  input  logic        ph2En,
  output ctlStrobes_t stb,
  output svcCode_t    code
);

  always_comb begin
    if (stat.resPend)                     code = SVC_RESET;
    else if (stat.nmiPend)                code = SVC_NMI;
    else if (stat.irqLow && !intDisable)  code = SVC_IRQ;
    else                                  code = SVC_NONE;
  end

  assign stb.takeNmi     = instrEnd & stat.nmiPend & ~stat.resPend;
  assign stb.fireRestart = stat.resPend & stat.resHigh & stat.relDone;
  assign stb.setHalt     = ph2En & opFetch & stat.rdyLow;

  AST_NO_TAKE_HELD: assert property (@(posedge clk) disable iff (!sysRstN)
    stat.resPend |-> !stb.takeNmi); // R5
  AST_MASKED: assert property (@(posedge clk) disable iff (!sysRstN)
    (intDisable && !stat.nmiPend && !stat.resPend) |-> (code == SVC_NONE)); // R2

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int RELEASE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       sysRstN,
  input  logic       irqPinN,
  input  logic       nmiPinN,
  input  logic       resPinN,
  input  logic       soPinN,
  input  logic       rdyPin,
  input  logic       intDisable,
  input  logic       instrEnd,
  input  logic       opFetch,
  input  logic       ph1Late,
  input  logic       ph2En,
  output logic       svcReq,
  output logic [1:0] svcCode,
  output logic       restartReq,
  output logic       coreHold,
  output logic       setOverflow,
  output logic       stall
);

  ctlStrobes_t stb;
  dpStatus_t   stat;
  svcCode_t    code;
  logic [PIN_COUNT-1:0] pinsRaw;

  always_comb begin
    pinsRaw          = '1;
    pinsRaw[PIN_IRQ] = irqPinN;
    pinsRaw[PIN_NMI] = nmiPinN;
    pinsRaw[PIN_RES] = resPinN;
    pinsRaw[PIN_SO]  = soPinN;
    pinsRaw[PIN_RDY] = rdyPin;
  end

  irqc_datapath #(.SYNC_STAGES(SYNC_STAGES), .RELEASE_CYCLES(RELEASE_CYCLES)) uDp (
    .clk         (clk),
    .sysRstN     (sysRstN),
    .pinsRaw     (pinsRaw),
    .ph1Late     (ph1Late),
    .stb         (stb),
    .stat        (stat),
    .restartReq  (restartReq),
    .coreHold    (coreHold),
    .setOverflow (setOverflow),
    .stall       (stall)
  );

  irqc_control uCtl (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .stat       (stat),
    .intDisable (intDisable),
    .instrEnd   (instrEnd),
    .opFetch    (opFetch),
    .ph2En      (ph2En),
    .stb        (stb),
    .code       (code)
  );

  assign svcCode = code;
  assign svcReq  = (code != SVC_NONE);

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic irqPinN = 1'b1, nmiPinN = 1'b1, resPinN = 1'b1, soPinN = 1'b1, rdyPin = 1'b1;
  logic intDisable = 1'b0, instrEnd = 1'b0, opFetch = 1'b0, ph1Late = 1'b0, ph2En = 1'b0;
  logic svcReq, restartReq, coreHold, setOverflow, stall;
  logic [1:0] svcCode;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irqc_top #(.SYNC_STAGES(2), .RELEASE_CYCLES(3)) uut (
    .clk(clk), .sysRstN(sysRstN), .irqPinN(irqPinN), .nmiPinN(nmiPinN),
    .resPinN(resPinN), .soPinN(soPinN), .rdyPin(rdyPin), .intDisable(intDisable),
    .instrEnd(instrEnd), .opFetch(opFetch), .ph1Late(ph1Late), .ph2En(ph2En),
    .svcReq(svcReq), .svcCode(svcCode), .restartReq(restartReq), .coreHold(coreHold),
    .setOverflow(setOverflow), .stall(stall)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitRestart(input string req, input int expEdges);
    int n = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      n++;
      if (restartReq) break;
    end
    chk(req, "restart latency", n, expEdges);
  endtask

  task automatic tInitial;
    chk("R8", "coreHold after sysRstN", coreHold, 1);
    chk("R8", "svcCode after sysRstN", svcCode, 3);
    waitRestart("R8", 3);
    chk("R8", "code after power-on restart", svcCode, 0);
  endtask

  task automatic tIrq;
    chk("R5", "idle svcReq", svcReq, 0);
    irqPinN = 1'b0;
    step(1);
    chk("R1", "irq after one edge", svcCode, 0);
    step(1);
    chk("R2", "irq after two edges", svcCode, 1);
    chk("R5", "svcReq with irq", svcReq, 1);
    intDisable = 1'b1;
    step(1);
    chk("R2", "irq masked", svcCode, 0);
    chk("R2", "svcReq masked", svcReq, 0);
    intDisable = 1'b0;
    irqPinN = 1'b1;
    step(3);
    chk("R2", "irq released", svcCode, 0);
  endtask

  task automatic tNmi;
    nmiPinN = 1'b0;
    step(2);
    chk("R3", "nmi after two edges", svcCode, 0);
    step(1);
    chk("R3", "nmi after three edges", svcCode, 2);
    step(8);
    chk("R4", "nmi still pending", svcCode, 2);
    instrEnd = 1'b1;
    step(1);
    instrEnd = 1'b0;
    chk("R4", "nmi cleared by boundary", svcCode, 0);
    step(5);
    chk("R3", "held low no repeat", svcCode, 0);
    nmiPinN = 1'b1;
    step(3);
    nmiPinN = 1'b0;
    step(3);
    chk("R3", "second edge pending", svcCode, 2);
    instrEnd = 1'b1;
    step(1);
    instrEnd = 1'b0;
    nmiPinN = 1'b1;
    step(3);
  endtask

  task automatic tPriority;
    irqPinN = 1'b0;
    step(2);
    chk("R5", "irq alone", svcCode, 1);
    nmiPinN = 1'b0;
    step(3);
    chk("R5", "nmi over irq", svcCode, 2);
    instrEnd = 1'b1;
    step(1);
    instrEnd = 1'b0;
    chk("R5", "irq after nmi taken", svcCode, 1);
    resPinN = 1'b0;
    step(3);
    chk("R5", "reset over irq", svcCode, 3);
    irqPinN = 1'b1;
    nmiPinN = 1'b1;
    resPinN = 1'b1;
    waitRestart("R6", 5);
    step(3);
  endtask

  task automatic tRestart;
    resPinN = 1'b0;
    step(2);
    chk("R6", "hold after two edges", coreHold, 0);
    step(1);
    chk("R6", "hold after three edges", coreHold, 1);
    chk("R6", "code while held", svcCode, 3);
    nmiPinN = 1'b0;
    step(4);
    resPinN = 1'b1;
    waitRestart("R6", 5);
    chk("R6", "hold dropped at restart", coreHold, 0);
    chk("R12", "nmi discarded in reset", svcCode, 0);
    step(1);
    chk("R6", "restart pulse width", restartReq, 0);
    nmiPinN = 1'b1;
    step(3);
  endtask

  task automatic tGlitch;
    int seen = 0;
    resPinN = 1'b0;
    step(4);
    resPinN = 1'b1;
    step(2);
    resPinN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (restartReq) seen++;
    end
    chk("R7", "glitch restarts", seen, 0);
    chk("R7", "hold after glitch", coreHold, 1);
    resPinN = 1'b1;
    waitRestart("R7", 5);
    step(2);
  endtask

  task automatic tOverflow;
    int seen = 0;
    ph1Late = 1'b0;
    soPinN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (setOverflow) seen++;
    end
    chk("R10", "no pulse outside phase", seen, 0);
    ph1Late = 1'b1;
    step(1);
    chk("R10", "pulse when phase opens", setOverflow, 1);
    step(1);
    chk("R9", "pulse one cycle", setOverflow, 0);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      step(1);
      if (setOverflow) seen++;
    end
    chk("R9", "held low no repeat", seen, 0);
    soPinN = 1'b1;
    step(4);
    soPinN = 1'b0;
    step(2);
    chk("R9", "pulse after two edges", setOverflow, 0);
    step(1);
    chk("R9", "pulse after three edges", setOverflow, 1);
    step(1);
    chk("R9", "second pulse width", setOverflow, 0);
    soPinN = 1'b1;
    ph1Late = 1'b0;
    step(3);
  endtask

  task automatic tStall;
    ph2En = 1'b1;
    opFetch = 1'b0;
    rdyPin = 1'b0;
    step(5);
    chk("R11", "no stall without fetch", stall, 0);
    opFetch = 1'b1;
    step(1);
    chk("R11", "stall at fetch", stall, 1);
    opFetch = 1'b0;
    step(3);
    chk("R11", "stall held", stall, 1);
    rdyPin = 1'b1;
    step(2);
    chk("R11", "stall before sync", stall, 1);
    step(1);
    chk("R11", "stall released", stall, 0);
    ph2En = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL all watchdog actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    sysRstN = 1'b1;
    #1;
    tInitial();
    tIrq();
    tNmi();
    tPriority();
    tRestart();
    tGlitch();
    tOverflow();
    tStall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule